// File: doc/BRIEF.md
# Clock Control Register File

This block is the software-visible register bank of a chip's clock and reset controller. It sits on a 32-bit bus that only takes aligned word accesses. It holds clock enables, a clock select word, dividers, IP reset words, watchdog reset control words and four PLL control words. The stored values drive the rest of the clock tree. The block contains no PLLs, dividers or reset sequencing of its own. The two counter slots belong to a separate timer block, so here they read as zero.

Each word is loaded with a fixed value on cold reset. A plain word stores whatever is written to it. A PLL control word rewrites its own status bits on every write:

- Bit 31 means "locked".
- Bit 30 is a sticky lock-loss flag, cleared by writing 1 to it.
- Bit 12 requests power-down.

The software reset word always reads zero. Accesses outside the implemented words, and accesses that are not word-aligned, read zero and change nothing. Read data appears on `bus_rdata` in the cycle after the request. In all other cycles `bus_rdata` is zero.

Top module: `clkctl_regs`

## Requirements
- R1: After reset, these words read all ones: 0x00, 0x28, 0x30, 0x38, 0x3C and 0x40. Word 0x04 reads 0x004AAAAA, 0x08 reads 0x5413F855 and 0x2C reads 0xAA4F8F9F. Every other storing word, for example 0x18 and 0x20, reads zero.
- R2: After reset, the PLL control words read as follows: 0x0C reads 0x80222101, 0x10 reads 0x80202101, 0x54 reads 0x80C02105 and 0x60 reads 0x81228606.
- R3: A write to a plain storing word stores all 32 data bits. The new value is returned by a read issued in the next cycle.
- R4: A write to a PLL control word with bit 12 set stores the written value with bit 31 forced to 0 and bit 30 forced to 1. This holds even when bit 30 or bit 31 is written as 1.
- R5: A write to a PLL control word with bit 12 clear stores bit 31 as 1. If the written bit 30 is 1, the stored bit 30 becomes 0. All other bits are stored as written.
- R6: A write to a PLL control word with bit 12 clear and bit 30 written as 0 leaves the stored bit 30 at its previous value.
- R7: Word 0x14 (software reset) reads zero, including after a write of any value.
- R8: Words 0x68 and 0x6C (counter slots) read zero, and writes to them change nothing.
- R9: Reads at byte offsets 0x70 up to 0xFFC return zero. Writes there change no register, and an offset whose low bits match a real word does not alias onto it.
- R10: An access whose address bits [1:0] are not 00 is ignored: a write changes nothing and a read returns zero.
- R11: `bus_rdata` holds the read word in the cycle after a read request and is zero in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read request |

## Verification
The interesting same-cycle collision is inside one PLL write: the power-down request and the lock-loss clear can both be set in the same data word. The bench provokes this by writing a word with both bit 12 and bit 30 set, and again with bit 31 set as well. It expects power-down to win, so bit 31 reads 0 and bit 30 reads 1. A second overlap is a write followed at once by a read of the same word. That read must return the value written one cycle earlier, and a scoreboard judges it against values computed from the write rules.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 28;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int LOCK_BIT  = 31;
  localparam int LOSS_BIT  = 30;
  localparam int PDN_BIT   = 12;

  typedef enum logic [1:0] {K_STORE, K_PLL, K_ZERO} slot_kind_e;

  // Behaviour class of each word slot
  function automatic slot_kind_e kind_of(int i);
    case (i)
      3, 4, 21, 24: return K_PLL;
      5, 26, 27:    return K_ZERO;
      default:      return K_STORE;
    endcase
  endfunction

  // Cold reset value of each word slot
  function automatic logic [DATA_W-1:0] reset_of(int i);
    case (i)
      0, 10, 12, 14, 15, 16: return '1;
      1:       return 32'h004A_AAAA;
      2:       return 32'h5413_F855;
      11:      return 32'hAA4F_8F9F;
      3:       return 32'h8022_2101;
      4:       return 32'h8020_2101;
      21:      return 32'h80C0_2105;
      24:      return 32'h8122_8606;
      default: return '0;
    endcase
  endfunction

  // Stored value of a PLL control word after a write
  function automatic logic [DATA_W-1:0] pll_next(logic [DATA_W-1:0] old_v,
                                                  logic [DATA_W-1:0] wr_v);
    logic [DATA_W-1:0] v;
    v = wr_v;
    if (wr_v[PDN_BIT]) begin
      v[LOCK_BIT] = 1'b0;
      v[LOSS_BIT] = 1'b1;
    end else begin
      v[LOCK_BIT] = 1'b1;
      v[LOSS_BIT] = wr_v[LOSS_BIT] ? 1'b0 : old_v[LOSS_BIT];
    end
    return v;
  endfunction
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(NUM_WORDS - 1);

  logic [WORD_W-1:0] word;
  logic              aligned;

  always_comb begin
    word    = addr[ADDR_W-1:2];
    aligned = (addr[1:0] == 2'b00);
    hit     = aligned && (word <= LAST_WORD);
    idx     = word[IDX_W-1:0];
  end
endmodule

// File: rtl/clkctl_slot.sv
module clkctl_slot
  import clkctl_pkg::*;
#(
  parameter bit                IS_PLL = 1'b0,
  parameter logic [DATA_W-1:0] RST    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= IS_PLL ? pll_next(q, wdata) : wdata;
  end

  a_r9_no_stray_change: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

  if (IS_PLL) begin : g_pll_chk
    a_r4_pdn_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[PDN_BIT]) |=> (!q[LOCK_BIT] && q[LOSS_BIT]));
    a_r5_loss_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wdata[PDN_BIT] && wdata[LOSS_BIT]) |=> (q[LOCK_BIT] && !q[LOSS_BIT]));
    a_r6_loss_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wdata[PDN_BIT] && !wdata[LOSS_BIT]) |=>
        (q[LOCK_BIT] && q[LOSS_BIT] == $past(q[LOSS_BIT])));
  end else begin : g_store_chk
    a_r3_store_all: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q == $past(wdata));
  end
endmodule

// File: rtl/clkctl_rdport.sv
module clkctl_rdport
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] words [NUM_WORDS],
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= words[idx];
    else            rdata <= '0;
  end
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int WINDOW_BYTES = 4096
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_valid,
  input  logic                            bus_write,
  input  logic [$clog2(WINDOW_BYTES)-1:0] bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata
);
  localparam int ADDR_W = $clog2(WINDOW_BYTES);

  logic [IDX_W-1:0]  req_idx;
  logic              req_hit;
  logic              wr_hit;
  logic              rd_hit;
  logic [DATA_W-1:0] words [NUM_WORDS];

  clkctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .idx  (req_idx),
    .hit  (req_hit)
  );

  assign wr_hit = bus_valid && bus_write && req_hit;
  assign rd_hit = bus_valid && !bus_write && req_hit;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
    localparam slot_kind_e KIND = kind_of(g);
    if (KIND == K_ZERO) begin : g_zero
      assign words[g] = '0;
    end else begin : g_reg
      logic we;
      assign we = wr_hit && (req_idx == IDX_W'(g));
      clkctl_slot #(.IS_PLL(KIND == K_PLL), .RST(reset_of(g))) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wdata (bus_wdata),
        .q     (words[g])
      );
    end
  end

  clkctl_rdport u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (rd_hit),
    .idx   (req_idx),
    .words (words),
    .rdata (bus_rdata)
  );

  a_r11_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> bus_rdata == '0);
  a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !req_hit) |=> bus_rdata == '0);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> bus_rdata == '0);
endmodule

// File: tb/clkctl_regs_test.sv
`timescale 1ns/1ps
module clkctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        issued_q = 1'b0;

  always #4 clk = ~clk;

  clkctl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  always @(posedge clk) issued_q <= rst_n && bus_valid && !bus_write;

  // monitor: compares every read result and every idle cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (issued_q) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s rdata=%h exp=%h", t, bus_rdata, e);
        end
      end else begin
        total++;
        if (bus_rdata !== 32'h0) begin
          bad++;
          $display("FAIL R11 idle rdata=%h exp=%h", bus_rdata, 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog rdata=%h exp=done", bus_rdata);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(12'h000, 32'hFFFF_FFFF, "R1 clken1");
    rd(12'h004, 32'h004A_AAAA, "R1 clksel");
    rd(12'h008, 32'h5413_F855, "R1 div1");
    rd(12'h028, 32'hFFFF_FFFF, "R1 clken2");
    rd(12'h02C, 32'hAA4F_8F9F, "R1 div2");
    rd(12'h030, 32'hFFFF_FFFF, "R1 clken3");
    rd(12'h038, 32'hFFFF_FFFF, "R1 wd0");
    rd(12'h03C, 32'hFFFF_FFFF, "R1 wd1");
    rd(12'h040, 32'hFFFF_FFFF, "R1 wd2");
    rd(12'h020, 32'h0, "R1 unlisted");
    rd(12'h018, 32'h0, "R1 unlisted 0x18");
    // R2 PLL reset values
    rd(12'h00C, 32'h8022_2101, "R2 pll0");
    rd(12'h010, 32'h8020_2101, "R2 pll1");
    rd(12'h054, 32'h80C0_2105, "R2 pll2");
    rd(12'h060, 32'h8122_8606, "R2 pll3");
    idle();
    // R3 plain write then immediate read
    wr(12'h004, 32'h1234_5678);
    rd(12'h004, 32'h1234_5678, "R3 clksel");
    wr(12'h018, 32'hA5A5_A5A5);
    rd(12'h018, 32'hA5A5_A5A5, "R3 slot 0x18");
    idle();
    // R4, R5, R6 PLL write rules
    wr(12'h00C, 32'h0000_1234);
    rd(12'h00C, 32'h4000_1234, "R4 pdn");
    wr(12'h00C, 32'h0000_0500);
    rd(12'h00C, 32'hC000_0500, "R6 loss kept set");
    wr(12'h00C, 32'h4000_0500);
    rd(12'h00C, 32'h8000_0500, "R5 loss cleared");
    wr(12'h00C, 32'h0000_0077);
    rd(12'h00C, 32'h8000_0077, "R6 loss kept clear");
    wr(12'h00C, 32'h4000_1000);
    rd(12'h00C, 32'h4000_1000, "R4 pdn with clear");
    wr(12'h010, 32'hC000_1000);
    rd(12'h010, 32'h4000_1000, "R4 pdn lock written");
    wr(12'h060, 32'hFFFF_FFFF);
    rd(12'h060, 32'h7FFF_FFFF, "R4 pll3 ones");
    wr(12'h054, 32'h0000_0000);
    rd(12'h054, 32'h8000_0000, "R5 lock forced");
    idle();
    // R7 software reset word
    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h014, 32'h0, "R7 swrst");
    // R8 counter slots
    wr(12'h068, 32'h0000_DEAD);
    wr(12'h06C, 32'hBEEF_0000);
    rd(12'h068, 32'h0, "R8 cnt slot a");
    rd(12'h06C, 32'h0, "R8 cnt slot b");
    // R9 out of range
    rd(12'h070, 32'h0, "R9 first miss");
    rd(12'hFFC, 32'h0, "R9 top");
    wr(12'h080, 32'h1111_1111);
    wr(12'h08C, 32'h2222_2222);
    rd(12'h000, 32'hFFFF_FFFF, "R9 no alias 0x00");
    rd(12'h00C, 32'h4000_1000, "R9 no alias pll0");
    // R10 unaligned
    wr(12'h005, 32'h0000_0BAD);
    wr(12'h00E, 32'h0000_0000);
    rd(12'h004, 32'h1234_5678, "R10 write ignored");
    rd(12'h00C, 32'h4000_1000, "R10 pll write ignored");
    rd(12'h006, 32'h0, "R10 read zero");
    idle();
    idle();
    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule